// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block keeps two independent 40-bit event counters for a processor pipeline model. Each counter has its own control word. The control word picks one of 64 event codes and sets two privilege enables. It also chooses between occurrence counting and duration counting, and it enables an overflow pin. The pipeline presents one 64-bit strobe vector per counter each clock. A second 64-bit vector per counter flags that the selected event happened in both execution pipes in that clock. An event code therefore refers to a different source on each counter. Some codes are illegal on one of the two counters and never count there.

Software reaches the block through a small register bus. The bus is a write strobe with address and data, plus a combinational read port. Through it, software loads and reads back both counter values and the shared control word.

When a counter rolls over past its top value with its overflow enable set, the counter's dedicated output pin goes high and stays high. The pin is held by a two-state machine per counter. In `OVF_IDLE` the pin is low. The transition "wrap seen" moves it to `OVF_ASSERTED`, where the pin is high. The transition "software clear" returns it to `OVF_IDLE`. A software clear is either a write to that counter or a control write that leaves its overflow enable at 0. The block never raises a processor interrupt.

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset both counters read 0, the control word reads 0 and both overflow pins are low.
- R2: Register address 0 is the control word, address 1 is counter 0, address 2 is counter 1, and address 3 reads 0. The read port shows the addressed register in the same cycle. Each counter's control field is 10 bits: bits 5:0 event code, bit 6 OS enable, bit 7 user enable, bit 8 duration mode, bit 9 overflow enable. Counter 0's field sits at control bits 9:0 and counter 1's field at bits 25:16.
- R3: In event mode, a counter adds 1 on each clock in which its selected strobe is high and the privilege level is enabled.
- R4: In event mode, a counter adds 2 on a clock in which both its selected strobe and the matching dual-pipe bit are high.
- R5: In duration mode, a counter adds exactly 1 per clock while its selected strobe is high, whatever the dual-pipe bit.
- R6: Privilege levels 0, 1 and 2 count only when the OS enable is set. Level 3 counts only when the user enable is set.
- R7: Counter 0 takes its strobes from its own vector and counter 1 from its own, so one code selects different events on the two counters.
- R8: A code outside a counter's legal mask never counts on that counter. By default, code 63 is illegal on counter 0 and code 62 is illegal on counter 1.
- R9: A counter wraps modulo 2^40: one step from 2^40-1 gives 0, and a double step from 2^40-1 gives 1.
- R10: A wrap with the overflow enable set raises that counter's pin in the same cycle the wrapped value appears. The pin stays high until software writes that counter or writes the control word with that overflow enable at 0. A wrap with the enable at 0 leaves the pin low.
- R11: A software write to a counter in the same clock as an increment stores the written value, and no wrap is taken from that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| ev0_vec | input | 64 | Event strobes seen by counter 0, one bit per code |
| pair0_vec | input | 64 | Dual-pipe flags for counter 0's strobes |
| ev1_vec | input | 64 | Event strobes seen by counter 1 |
| pair1_vec | input | 64 | Dual-pipe flags for counter 1's strobes |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 40 | Register write data |
| bus_rdata | output | 40 | Read data for bus_addr |
| ovf_pin | output | 2 | Overflow pins, bit n for counter n |

## Verification
The bench drives counters to 2^40-2 and 2^40-1 and then steps them by one or by two. A design with a missing carry, or one that signals overflow a cycle late, would show the wrong value or the wrong pin timing there. The bench collides a software write with a live increment and with a pending wrap. A design that let the increment win would store the written value plus one or raise a spurious pin. It selects codes that are illegal on one counter and codes that are shared, and it raises only one counter's strobe vector. It sweeps privilege levels against each enable, and it holds the dual-pipe flag high in duration mode, where a design that doubled would count twice as fast.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int SEL_W  = 6;
    localparam int CTRL_W = SEL_W + 4;

    typedef struct packed {
        logic             ovf_en;
        logic             dur;
        logic             usr_en;
        logic             os_en;
        logic [SEL_W-1:0] sel;
    } pmu_ctrl_t;

    typedef enum logic {
        OVF_IDLE     = 1'b0,
        OVF_ASSERTED = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick
    import pmu_pkg::*;
#(
    parameter int              NUM_EV     = 64,
    parameter logic [NUM_EV-1:0] VALID_MASK = '1
) (
    input  pmu_ctrl_t          ctrl,
    input  logic [1:0]         priv_lvl,
    input  logic [NUM_EV-1:0]  ev_vec,
    input  logic [NUM_EV-1:0]  pair_vec,
    output logic [1:0]         inc
);
    logic hit;
    logic both;
    logic priv_ok;

    always_comb begin
        hit     = ev_vec[ctrl.sel] & VALID_MASK[ctrl.sel];
        both    = pair_vec[ctrl.sel];
        priv_ok = (priv_lvl == 2'd3) ? ctrl.usr_en : ctrl.os_en;
        if (!(hit && priv_ok)) begin
            inc = 2'd0;
        end else if (ctrl.dur) begin
            inc = 2'd1;
        end else if (both) begin
            inc = 2'd2;
        end else begin
            inc = 2'd1;
        end
    end
endmodule

// File: rtl/pmu_count_reg.sv
module pmu_count_reg #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       inc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum  = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
        wrap = sum[CNT_W] & ~wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pmu_ovf_fsm.sv
module pmu_ovf_fsm
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pin
);
    ovf_state_e state_q;
    ovf_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OVF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE:     if (set_req && !clr_req) state_d = OVF_ASSERTED;
            OVF_ASSERTED: if (clr_req)             state_d = OVF_IDLE;
            default:      state_d = OVF_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OVF_ASSERTED: pin = 1'b1;
            default:      pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int                         CNT_W       = 40,
    parameter logic [(1<<SEL_W)-1:0]      VALID0_MASK = {1'b0, {((1<<SEL_W)-1){1'b1}}},
    parameter logic [(1<<SEL_W)-1:0]      VALID1_MASK = {2'b10, {((1<<SEL_W)-2){1'b1}}}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              priv_lvl,
    input  logic [(1<<SEL_W)-1:0]   ev0_vec,
    input  logic [(1<<SEL_W)-1:0]   pair0_vec,
    input  logic [(1<<SEL_W)-1:0]   ev1_vec,
    input  logic [(1<<SEL_W)-1:0]   pair1_vec,
    input  logic                    bus_wen,
    input  logic [1:0]              bus_addr,
    input  logic [CNT_W-1:0]        bus_wdata,
    output logic [CNT_W-1:0]        bus_rdata,
    output logic [1:0]              ovf_pin
);
    localparam int NUM_EV   = 1 << SEL_W;
    localparam int NUM_CNT  = 2;
    localparam int C1_LSB   = 16;
    localparam int CTRL_TOP = C1_LSB + CTRL_W;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT0 = 2'd1;
    localparam logic [1:0] A_CNT1 = 2'd2;

    logic [NUM_CNT-1:0][NUM_EV-1:0] ev_all;
    logic [NUM_CNT-1:0][NUM_EV-1:0] pair_all;
    pmu_ctrl_t [NUM_CNT-1:0]        ctrl_q;
    pmu_ctrl_t [NUM_CNT-1:0]        ctrl_wr;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_val;
    logic [NUM_CNT-1:0]             cnt_wr;
    logic [NUM_CNT-1:0]             ovf_en_q;
    logic [NUM_CNT-1:0]             dur_q;
    logic [NUM_CNT-1:0]             cnt_en_q;
    logic                           ctrl_we;

    assign ev_all[0]   = ev0_vec;
    assign ev_all[1]   = ev1_vec;
    assign pair_all[0] = pair0_vec;
    assign pair_all[1] = pair1_vec;

    assign ctrl_we    = bus_wen && (bus_addr == A_CTRL);
    assign cnt_wr[0]  = bus_wen && (bus_addr == A_CNT0);
    assign cnt_wr[1]  = bus_wen && (bus_addr == A_CNT1);
    assign ctrl_wr[0] = bus_wdata[CTRL_W-1:0];
    assign ctrl_wr[1] = bus_wdata[C1_LSB+CTRL_W-1:C1_LSB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wr;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam logic [NUM_EV-1:0] MASK = (g == 0) ? VALID0_MASK : VALID1_MASK;
        logic [1:0] inc;
        logic       wrap;
        logic       clr;

        pmu_evt_pick #(
            .NUM_EV     (NUM_EV),
            .VALID_MASK (MASK)
        ) u_pick (
            .ctrl     (ctrl_q[g]),
            .priv_lvl (priv_lvl),
            .ev_vec   (ev_all[g]),
            .pair_vec (pair_all[g]),
            .inc      (inc)
        );

        pmu_count_reg #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cnt_wr[g]),
            .wr_data (bus_wdata),
            .inc     (inc),
            .cnt_q   (cnt_val[g]),
            .wrap    (wrap)
        );

        assign clr = cnt_wr[g] || (ctrl_we && !ctrl_wr[g].ovf_en);

        pmu_ovf_fsm u_ovf (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (wrap && ctrl_q[g].ovf_en),
            .clr_req (clr),
            .pin     (ovf_pin[g])
        );

        assign ovf_en_q[g] = ctrl_q[g].ovf_en;
        assign dur_q[g]    = ctrl_q[g].dur;
        assign cnt_en_q[g] = ctrl_q[g].os_en | ctrl_q[g].usr_en;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_W-1:0]        = ctrl_q[0];
                bus_rdata[CTRL_TOP-1:C1_LSB] = ctrl_q[1];
            end
            A_CNT0:  bus_rdata = cnt_val[0];
            A_CNT1:  bus_rdata = cnt_val[1];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmu_dual_counter_chk.sv
module pmu_dual_counter_chk #(
    parameter int CNT_W = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wen,
    input logic [1:0]             bus_addr,
    input logic [CNT_W-1:0]       bus_wdata,
    input logic [1:0][CNT_W-1:0]  cnt_val,
    input logic [1:0]             ovf_pin,
    input logic [1:0]             ovf_en_q,
    input logic [1:0]             dur_q,
    input logic [1:0]             cnt_en_q
);
    logic wr0;
    logic wr1;
    assign wr0 = bus_wen && (bus_addr == 2'd1);
    assign wr1 = bus_wen && (bus_addr == 2'd2);

    // R11
    wr0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> cnt_val[0] == $past(bus_wdata));

    // R11
    wr1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr1 |=> cnt_val[1] == $past(bus_wdata));

    // R4
    step0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr0 |=> (cnt_val[0] - $past(cnt_val[0])) <= CNT_W'(2));

    // R5
    dur_step0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dur_q[0] && !wr0) |=> (cnt_val[0] - $past(cnt_val[0])) <= CNT_W'(1));

    // R6
    idle0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_q[0] && !wr0) |=> $stable(cnt_val[0]));

    // R10
    pin_rise0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pin[0]) |-> cnt_val[0] <= CNT_W'(1));

    // R10
    pin_gate0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_en_q[0] |-> !ovf_pin[0]);

    // R10
    pin_gate1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_en_q[1] |-> !ovf_pin[1]);
endmodule

bind pmu_dual_counter pmu_dual_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .ovf_pin   (ovf_pin),
    .ovf_en_q  (ovf_en_q),
    .dur_q     (dur_q),
    .cnt_en_q  (cnt_en_q)
);

// File: tb/pmu_dual_counter_bench.sv
module pmu_dual_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 40;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    priv_lvl = 2'd0;
    logic [63:0]   ev0_vec = '0, pair0_vec = '0, ev1_vec = '0, pair1_vec = '0;
    logic          bus_wen = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [1:0]    ovf_pin;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_dual_counter u_pmu_dual_counter (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl),
        .ev0_vec(ev0_vec), .pair0_vec(pair0_vec),
        .ev1_vec(ev1_vec), .pair1_vec(pair1_vec),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_pin(ovf_pin)
    );

    function automatic logic [9:0] cw(input logic [5:0] sel, input bit os, input bit usr,
                                      input bit dur, input bit oven);
        return {oven, dur, usr, os, sel};
    endfunction

    function automatic logic [W-1:0] cword(input logic [9:0] c0, input logic [9:0] c1);
        logic [W-1:0] w;
        w = '0;
        w[9:0]   = c0;
        w[25:16] = c1;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic run(input logic [5:0] code, input bit on0, input bit on1,
                       input bit dual, input int n);
        @(negedge clk);
        ev0_vec[code] = on0; ev1_vec[code] = on1;
        pair0_vec[code] = dual; pair1_vec[code] = dual;
        repeat (n) @(negedge clk);
        ev0_vec = '0; ev1_vec = '0; pair0_vec = '0; pair1_vec = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 2'd0, '0);
        rd_chk("R1 cnt0", 2'd1, '0);
        rd_chk("R1 cnt1", 2'd2, '0);
        chk("R1 pins", {38'd0, ovf_pin}, '0);
        rd_chk("R2 addr3", 2'd3, '0);
    endtask

    task automatic t_event;
        wr(2'd0, cword(cw(6'd5, 1, 1, 0, 0), cw(6'd9, 1, 0, 1, 1)));
        rd_chk("R2 ctrl readback", 2'd0, cword(cw(6'd5, 1, 1, 0, 0), cw(6'd9, 1, 0, 1, 1)));
        priv_lvl = 2'd0;
        run(6'd5, 1, 0, 0, 3);
        rd_chk("R3 event count", 2'd1, 40'd3);
        rd_chk("R3 other counter idle", 2'd2, 40'd0);
    endtask

    task automatic t_dual;
        wr(2'd1, '0);
        run(6'd5, 1, 0, 1, 4);
        rd_chk("R4 dual pipe adds two", 2'd1, 40'd8);
    endtask

    task automatic t_duration;
        wr(2'd0, cword(cw(6'd5, 1, 1, 1, 0), 10'd0));
        wr(2'd1, '0);
        run(6'd5, 1, 0, 1, 5);
        rd_chk("R5 duration ignores pair", 2'd1, 40'd5);
    endtask

    task automatic t_priv;
        wr(2'd0, cword(cw(6'd5, 1, 0, 0, 0), 10'd0));
        wr(2'd1, '0);
        priv_lvl = 2'd3;
        run(6'd5, 1, 0, 0, 3);
        rd_chk("R6 os-only blocks level 3", 2'd1, 40'd0);
        priv_lvl = 2'd1;
        run(6'd5, 1, 0, 0, 3);
        rd_chk("R6 os-only counts level 1", 2'd1, 40'd3);
        wr(2'd0, cword(cw(6'd5, 0, 1, 0, 0), 10'd0));
        priv_lvl = 2'd2;
        run(6'd5, 1, 0, 0, 2);
        rd_chk("R6 usr-only blocks level 2", 2'd1, 40'd3);
        priv_lvl = 2'd3;
        run(6'd5, 1, 0, 0, 2);
        rd_chk("R6 usr-only counts level 3", 2'd1, 40'd5);
        priv_lvl = 2'd0;
    endtask

    task automatic t_map;
        wr(2'd0, cword(cw(6'h10, 1, 1, 0, 0), cw(6'h10, 1, 1, 0, 0)));
        wr(2'd1, '0);
        wr(2'd2, '0);
        run(6'h10, 1, 0, 0, 2);
        rd_chk("R7 cnt0 sees own vector", 2'd1, 40'd2);
        rd_chk("R7 cnt1 ignores cnt0 vector", 2'd2, 40'd0);
        run(6'h10, 0, 1, 0, 3);
        rd_chk("R7 cnt1 sees own vector", 2'd2, 40'd3);
        rd_chk("R7 cnt0 ignores cnt1 vector", 2'd1, 40'd2);
    endtask

    task automatic t_illegal;
        wr(2'd0, cword(cw(6'd63, 1, 1, 0, 0), cw(6'd63, 1, 1, 0, 0)));
        wr(2'd1, '0);
        wr(2'd2, '0);
        run(6'd63, 1, 1, 0, 3);
        rd_chk("R8 code 63 illegal on cnt0", 2'd1, 40'd0);
        rd_chk("R8 code 63 legal on cnt1", 2'd2, 40'd3);
        wr(2'd0, cword(cw(6'd62, 1, 1, 0, 0), cw(6'd62, 1, 1, 0, 0)));
        run(6'd62, 1, 1, 0, 2);
        rd_chk("R8 code 62 illegal on cnt1", 2'd2, 40'd3);
        rd_chk("R8 code 62 legal on cnt0", 2'd1, 40'd2);
    endtask

    task automatic t_wrap;
        wr(2'd0, cword(cw(6'd5, 1, 1, 0, 1), 10'd0));
        wr(2'd1, TOP - 40'd1);
        @(negedge clk);
        ev0_vec[5] = 1'b1;
        @(negedge clk);
        rd_chk("R9 reach top", 2'd1, TOP);
        chk("R10 pin low before wrap", {39'd0, ovf_pin[0]}, 40'd0);
        @(negedge clk);
        ev0_vec = '0;
        rd_chk("R9 wrap to zero", 2'd1, 40'd0);
        chk("R10 pin high at wrap", {39'd0, ovf_pin[0]}, 40'd1);
        repeat (3) @(negedge clk);
        chk("R10 pin held", {39'd0, ovf_pin[0]}, 40'd1);
        wr(2'd0, cword(cw(6'd5, 1, 1, 0, 0), 10'd0));
        chk("R10 pin cleared by enable off", {39'd0, ovf_pin[0]}, 40'd0);
        wr(2'd1, TOP);
        run(6'd5, 1, 0, 1, 1);
        rd_chk("R9 double step wraps to one", 2'd1, 40'd1);
        chk("R10 no pin when disabled", {39'd0, ovf_pin[0]}, 40'd0);
        wr(2'd0, cword(cw(6'd5, 1, 1, 0, 1), 10'd0));
        wr(2'd1, TOP);
        run(6'd5, 1, 0, 1, 1);
        chk("R10 pin on double step", {39'd0, ovf_pin[0]}, 40'd1);
        wr(2'd1, 40'd20);
        chk("R10 pin cleared by counter write", {39'd0, ovf_pin[0]}, 40'd0);
    endtask

    task automatic t_wins;
        wr(2'd0, cword(cw(6'd5, 1, 1, 0, 1), 10'd0));
        @(negedge clk);
        ev0_vec[5] = 1'b1; bus_addr = 2'd1; bus_wdata = 40'd100; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; ev0_vec = '0;
        rd_chk("R11 write beats increment", 2'd1, 40'd100);
        wr(2'd1, TOP);
        @(negedge clk);
        ev0_vec[5] = 1'b1; bus_addr = 2'd1; bus_wdata = 40'd7; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; ev0_vec = '0;
        rd_chk("R11 write beats wrap", 2'd1, 40'd7);
        chk("R11 no pin from blocked wrap", {39'd0, ovf_pin[0]}, 40'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event();
        t_dual();
        t_duration();
        t_priv();
        t_map();
        t_illegal();
        t_wrap();
        t_wins();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule